// File: doc/BRIEF.md
# ATA Device Task-File Controller

This block is the command and status register file on the device side of a parallel ATA disk. A host reaches it through a small I/O port made of a 3-bit offset, separate read and write strobes and a 16-bit data bus. The host loads the sector count, the three LBA bytes and the device/head byte, then writes an opcode to the command port. It learns progress by reading the status port, which shares that offset. A status read also withdraws any pending interrupt.

Four commands are handled. IDENTIFY offers a fixed block of 256 words through the data port in PIO data-in fashion, with the words generated from constants inside the block. FLUSH CACHE holds the device busy until an external flush-done pulse arrives. READ DMA and WRITE DMA latch the address and count, hand a request to an outside bus-master engine and wait for its done pulse. Every other opcode is rejected with an error. The media and the DMA data path sit outside the block.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status (offset 7 read, low byte) reads 0x40 (DRDY only), irq is low and dma_req is low.
- R2: Writes to offsets 2 (sector count), 3, 4, 5 (LBA bits 7:0, 15:8, 23:16) and 6 (device/head) store the low data byte, and a read of the same offset returns it zero-extended to 16 bits.
- R3: In the device/head byte, bit 4 (0x10) selects device 1 and bit 6 (0x40) selects LBA mode. Writing 0x40 and reading it back gives bit 4 clear.
- R4: Opcode 0xEC (IDENTIFY) raises irq, and before each of exactly 256 data-port (offset 0) word reads, status reads 0x48 (DRDY and DRQ set, BSY, DF=0x20 and ERR=0x01 clear).
- R5: After the 256th IDENTIFY word has been read, status reads 0x40 and further data-port reads return 0.
- R6: IDENTIFY word 0 is 0x0040 and word 85 is 0x0020 (write cache enabled). Words 10 to 19 hold the 20-character serial string and words 23 to 26 hold the 8-character revision string, two ASCII characters per word with the first character in bits 15:8. All other words are 0.
- R7: Opcode 0xE7 (FLUSH CACHE) makes status read 0xC0 (BSY and DRDY) until flush_done is pulsed. Then status reads 0x40 and irq rises.
- R8: Opcodes 0xC8 (read, dma_to_mem=1) and 0xCA (write, dma_to_mem=0) make status 0xC0, assert dma_req, and present the LBA {offset 5, 4, 3} on dma_lba and the sector count on dma_count.
- R9: A dma_done pulse while dma_req is high drops dma_req, makes status 0x40 and raises irq.
- R10: Any other opcode makes status 0x41 (ERR set, BSY clear) and raises irq. The next accepted command clears ERR.
- R11: A read of offset 7 clears irq. Reads of other offsets leave it unchanged.
- R12: A data-port read while DRQ is clear returns 0 and changes no state.
- R13: A command write while BSY is set is ignored, and flush_done or dma_done with no matching command outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 3 | Register offset |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 16 | Write data (registers use bits 7:0) |
| io_rdata | output | 16 | Read data for the current offset |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | Transfer request to the bus-master engine |
| dma_to_mem | output | 1 | 1 when data moves from device to memory |
| dma_lba | output | 24 | Latched starting LBA |
| dma_count | output | 8 | Latched sector count |
| dma_done | input | 1 | Transfer-complete pulse from the engine |
| flush_done | input | 1 | Cache-flush-complete pulse |

## Verification
Register write and readback are driven from a vector table with nonzero high bytes, so stray upper bits or a swapped offset decode show up. The full IDENTIFY burst is read word by word against contents the bench builds from its own copy of the strings, with status sampled before each word. This separates an off-by-one word count, a byte-order swap and a wrong DRQ drop point. FLUSH, both DMA directions, a rejected opcode, commands issued while busy and stray done pulses each exercise one status transition, and the checks also follow irq across status and non-status reads.

// File: rtl/ata_taskfile.sv
module ata_taskfile #(
  parameter int          ID_WORDS = 256,
  parameter logic [159:0] SERIAL   = "TFC-SERIAL-000000042",
  parameter logic [63:0]  REVISION = "REV 1.00"
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [15:0] io_wdata,
  output logic [15:0] io_rdata,
  output logic        irq,
  output logic        dma_req,
  output logic        dma_to_mem,
  output logic [23:0] dma_lba,
  output logic [7:0]  dma_count,
  input  logic        dma_done,
  input  logic        flush_done
);
  localparam int IDX_W = $clog2(ID_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WORDS - 1);

  logic [7:0] cnt_q, lba0_q, lba1_q, lba2_q, dev_q;
  logic       bsy_q, drq_q, err_q, flush_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] status_q;

  wire cmd_wr  = io_wr && io_addr == 3'd7 && !bsy_q;
  wire data_rd = io_rd && io_addr == 3'd0 && drq_q;
  wire [7:0] op = io_wdata[7:0];

  assign status_q = {bsy_q, 1'b1, 1'b0, 1'b0, drq_q, 2'b00, err_q};

  function automatic logic [15:0] id_word(input logic [IDX_W-1:0] i);
    logic [15:0] w;
    w = 16'h0000;
    if (int'(i) == 0)  w = 16'h0040;
    if (int'(i) == 85) w = 16'h0020;
    for (int k = 0; k < 10; k++)
      if (int'(i) == 10 + k) w = SERIAL[159 - 16*k -: 16];
    for (int k = 0; k < 4; k++)
      if (int'(i) == 23 + k) w = REVISION[63 - 16*k -: 16];
    return w;
  endfunction

  always_comb begin
    case (io_addr)
      3'd0:    io_rdata = drq_q ? id_word(idx_q) : 16'h0000;
      3'd2:    io_rdata = {8'h00, cnt_q};
      3'd3:    io_rdata = {8'h00, lba0_q};
      3'd4:    io_rdata = {8'h00, lba1_q};
      3'd5:    io_rdata = {8'h00, lba2_q};
      3'd6:    io_rdata = {8'h00, dev_q};
      3'd7:    io_rdata = {8'h00, status_q};
      default: io_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; lba0_q <= '0; lba1_q <= '0; lba2_q <= '0; dev_q <= '0;
      bsy_q <= 1'b0; drq_q <= 1'b0; err_q <= 1'b0; flush_q <= 1'b0;
      idx_q <= '0; irq <= 1'b0;
      dma_req <= 1'b0; dma_to_mem <= 1'b0; dma_lba <= '0; dma_count <= '0;
    end else begin
      if (io_wr) begin
        case (io_addr)
          3'd2: cnt_q  <= io_wdata[7:0];
          3'd3: lba0_q <= io_wdata[7:0];
          3'd4: lba1_q <= io_wdata[7:0];
          3'd5: lba2_q <= io_wdata[7:0];
          3'd6: dev_q  <= io_wdata[7:0];
          default: ;
        endcase
      end

      if (io_rd && io_addr == 3'd7) irq <= 1'b0;

      if (data_rd) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == LAST_IDX) drq_q <= 1'b0;
      end

      if (flush_q && flush_done) begin
        flush_q <= 1'b0;
        bsy_q   <= 1'b0;
        irq     <= 1'b1;
      end

      if (dma_req && dma_done) begin
        dma_req <= 1'b0;
        bsy_q   <= 1'b0;
        irq     <= 1'b1;
      end

      if (cmd_wr) begin
        err_q <= 1'b0;
        drq_q <= 1'b0;
        case (op)
          8'hEC: begin
            drq_q <= 1'b1;
            idx_q <= '0;
            irq   <= 1'b1;
          end
          8'hE7: begin
            bsy_q   <= 1'b1;
            flush_q <= 1'b1;
          end
          8'hC8, 8'hCA: begin
            bsy_q      <= 1'b1;
            dma_req    <= 1'b1;
            dma_to_mem <= (op == 8'hC8);
            dma_lba    <= {lba2_q, lba1_q, lba0_q};
            dma_count  <= cnt_q;
          end
          default: begin
            err_q <= 1'b1;
            irq   <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ata_taskfile_chk.sv
module ata_taskfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  io_addr,
  input logic        io_rd,
  input logic        io_wr,
  input logic [15:0] io_rdata,
  input logic        irq,
  input logic        dma_req,
  input logic        dma_done,
  input logic        flush_done,
  input logic        flush_q,
  input logic [7:0]  status_q
);
  p_bsy_no_drq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[7] |-> !status_q[3]);

  p_dmareq_bsy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> status_q[7]);

  p_dma_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_done) |=> (!dma_req && irq && !status_q[7]));

  p_flush_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && flush_done) |=> (!status_q[7] && status_q[6] && irq));

  p_err_not_bsy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[0] |-> !status_q[7]);

  p_irq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 3'd7 && !io_wr && !dma_done && !flush_done) |=> !irq);

  p_data_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 3'd0 && !status_q[3]) |-> io_rdata == 16'h0000);

  p_busy_stays_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[7] && !dma_done && !flush_done) |=> status_q[7]);
endmodule

bind ata_taskfile ata_taskfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_rdata(io_rdata), .irq(irq), .dma_req(dma_req), .dma_done(dma_done),
  .flush_done(flush_done), .flush_q(flush_q), .status_q(status_q)
);

// File: tb/test_ata_taskfile.sv
module test_ata_taskfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [159:0] SER = "TFC-SERIAL-000000042";
  localparam logic [63:0]  REV = "REV 1.00";
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {8'd2, 16'hAB12, 16'h0012},
    {8'd3, 16'h5534, 16'h0034},
    {8'd4, 16'hFF56, 16'h0056},
    {8'd5, 16'h0178, 16'h0078},
    {8'd6, 16'h80E0, 16'h00E0},
    {8'd6, 16'h0050, 16'h0050},
    {8'd6, 16'h0040, 16'h0040}
  };

  logic clk = 0, rst_n = 0;
  logic [2:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0, dma_done = 0, flush_done = 0;
  logic [15:0] io_wdata = 0, io_rdata;
  logic irq, dma_req, dma_to_mem;
  logic [23:0] dma_lba;
  logic [7:0] dma_count;
  int checks = 0, fails = 0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_taskfile i_ata_taskfile (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq), .dma_req(dma_req),
    .dma_to_mem(dma_to_mem), .dma_lba(dma_lba), .dma_count(dma_count),
    .dma_done(dma_done), .flush_done(flush_done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1 d = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic pulse(input bit is_dma);
    @(negedge clk); if (is_dma) dma_done = 1; else flush_done = 1;
    @(negedge clk); dma_done = 0; flush_done = 0;
  endtask

  function automatic logic [15:0] exp_word(input int i);
    if (i == 0) return 16'h0040;
    if (i == 85) return 16'h0020;
    if (i >= 10 && i <= 19) return SER[159 - 16*(i-10) -: 16];
    if (i >= 23 && i <= 26) return REV[63 - 16*(i-23) -: 16];
    return 16'h0000;
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd7, rv);
    check("R1 status", rv, 16'h0040);
    check("R1 irq", irq, 0);
    check("R1 dma_req", dma_req, 0);

    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][34:32], VEC[v][31:16]);
      rd(VEC[v][34:32], rv);
      check(VEC[v][34:32] == 3'd6 ? "R3 device" : "R2 readback", rv, VEC[v][15:0]);
    end
    check("R3 dev bit clear", rv[4], 0);

    rd(3'd0, rv);
    check("R12 data idle", rv, 0);
    rd(3'd7, rv);
    check("R12 status unchanged", rv, 16'h0040);

    wr(3'd7, 16'h00EC);
    check("R4 irq", irq, 1);
    for (int w = 0; w < 256; w++) begin
      rd(3'd7, rv);
      check("R4 status", rv, 16'h0048);
      rd(3'd0, rv);
      check("R6 word", rv, exp_word(w));
    end
    rd(3'd7, rv);
    check("R5 status", rv, 16'h0040);
    rd(3'd0, rv);
    check("R5 data zero", rv, 0);

    wr(3'd7, 16'h00E7);
    rd(3'd7, rv);
    check("R7 busy", rv, 16'h00C0);
    pulse(1'b1);
    rd(3'd7, rv);
    check("R13 dma_done ignored", rv, 16'h00C0);
    wr(3'd7, 16'h00C8);
    check("R13 cmd ignored", dma_req, 0);
    pulse(1'b0);
    check("R7 irq", irq, 1);
    rd(3'd2, rv);
    check("R11 other read keeps irq", irq, 1);
    rd(3'd7, rv);
    check("R7 done status", rv, 16'h0040);
    check("R11 irq cleared", irq, 0);

    wr(3'd3, 16'h0012); wr(3'd4, 16'h0034); wr(3'd5, 16'h0056); wr(3'd2, 16'h0005);
    wr(3'd7, 16'h00C8);
    check("R8 dma_req", dma_req, 1);
    check("R8 dir read", dma_to_mem, 1);
    check("R8 lba", dma_lba, 24'h563412);
    check("R8 count", dma_count, 8'h05);
    rd(3'd7, rv);
    check("R8 busy", rv, 16'h00C0);
    pulse(1'b0);
    check("R13 flush_done ignored", dma_req, 1);
    pulse(1'b1);
    check("R9 dma_req low", dma_req, 0);
    check("R9 irq", irq, 1);
    rd(3'd7, rv);
    check("R9 status", rv, 16'h0040);

    wr(3'd2, 16'h0009);
    wr(3'd7, 16'h00CA);
    check("R8 dir write", dma_to_mem, 0);
    check("R8 count2", dma_count, 8'h09);
    pulse(1'b1);
    rd(3'd7, rv);
    check("R9 status2", rv, 16'h0040);

    wr(3'd7, 16'h0042);
    check("R10 irq", irq, 1);
    rd(3'd7, rv);
    check("R10 status", rv, 16'h0041);
    check("R11 irq cleared2", irq, 0);
    wr(3'd7, 16'h00E7);
    rd(3'd7, rv);
    check("R10 err cleared", rv, 16'h00C0);
    pulse(1'b0);
    rd(3'd7, rv);
    check("R7 status2", rv, 16'h0040);

    finish_run();
  end
endmodule